// File: doc/BRIEF.md
# E1 Far-End Block Error Counter

This block counts remote block-error reports carried in the E-bits of an E1 CRC4 multiframe. It watches the received serial stream, one bit per bit-clock enable, together with a frame-start pulse and a 4-bit frame index from an upstream framer. On the first bit of timeslot 0 in frames 13 and 15 it takes the bit, and a zero there counts as one far-end error.

Counting stops while frame alignment or CRC4 multiframe alignment is lost. A loss of only the signalling multiframe alignment does not stop it. The running count is 16 bits wide and is not visible to the host. A once-per-second strobe copies it into a holding register and restarts it from zero in the same cycle. The host reads the holding register as a high byte and a low byte. Both bytes come from one snapshot, so no update can slip in between the two reads. A host clear zeroes both the running count and the holding register.

Top module: `febe_counter`

## Requirements
- R1: After reset, `cnt_hi` and `cnt_lo` are both 0 and the running count is 0.
- R2: A bit is taken as an E-bit only in a cycle where `bit_en`=1, `frm_start`=1 and `frm_idx` (a 4-bit frame number from 0 to 15) equals 13 or 15. Bits in any other cycle never change the count.
- R3: Each E-bit that reads 0 adds exactly one to the running count. An E-bit that reads 1 adds nothing.
- R4: While `los_fas`=1 or `los_crc`=1, E-bits are not counted.
- R5: `los_cas`=1 on its own, with `los_fas`=0 and `los_crc`=0, does not stop counting.
- R6: When `snap`=1 and `clr`=0, the holding register loads the running count plus any error counted in that same cycle, and the running count becomes 0. The new value is visible on the outputs after that clock edge.
- R7: `cnt_hi` is bits 15:8 of the holding register and `cnt_lo` is bits 7:0. They change only on a snapshot or a clear.
- R8: `clr`=1 zeroes both the running count and the holding register. It takes priority over `snap` and over an error in the same cycle.
- R9: The running count wraps from 65535 to 0 on the next error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Received bit valid in this cycle |
| rx_bit | input | 1 | Received serial data bit |
| frm_start | input | 1 | Marks the first bit of timeslot 0 |
| frm_idx | input | 4 | Frame number within the multiframe, 0 to 15 |
| los_fas | input | 1 | Frame alignment lost |
| los_crc | input | 1 | CRC4 multiframe alignment lost |
| los_cas | input | 1 | Signalling multiframe alignment lost |
| snap | input | 1 | One-second snapshot-and-restart strobe |
| clr | input | 1 | Host clear of count and snapshot |
| cnt_hi | output | 8 | Snapshot count, high byte |
| cnt_lo | output | 8 | Snapshot count, low byte |

## Verification
The bench targets the following corner cases, with the failure each one would expose:
- **Neighbouring positions.** Zeros are placed at frame 14, and at frame 13 without the start pulse or without the bit enable. A design with a loose position decode would count them.
- **Alignment flags.** Each loss flag is raised by itself. A design that mixed up the flags would either miss errors under signalling loss or count them under frame or CRC loss.
- **Strobe coinciding with an error.** A snapshot is taken in the same cycle as an error. A design that dropped the coinciding event would report one less, and one that kept it would show it in the next second as well.
- **Clear against a pending snapshot, and counter wrap.** A clear is issued together with a pending snapshot, and 65537 errors are counted before one snapshot. A wrong priority would leave a nonzero readout, and a saturating counter would report 65535 instead of 1.

// File: rtl/febe_pkg.sv
package febe_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INC  = 2'd1,
    ACT_SNAP = 2'd2,
    ACT_CLR  = 2'd3
  } febe_act_e;

  localparam int unsigned FEBE_NUM_EPOS = 2;
endpackage

// File: rtl/febe_ebit_qual.sv
module febe_ebit_qual #(
  parameter int unsigned FRM_W   = 4,
  parameter int unsigned EFRM_A  = 13,
  parameter int unsigned EFRM_B  = 15,
  parameter bit          CAS_GATES = 1'b0
) (
  input  logic             bit_en,
  input  logic             frm_start,
  input  logic [FRM_W-1:0] frm_idx,
  input  logic             rx_bit,
  input  logic             los_fas,
  input  logic             los_crc,
  input  logic             los_cas,
  output logic             err_evt
);
  import febe_pkg::*;

  localparam int unsigned EPOS [FEBE_NUM_EPOS] = '{EFRM_A, EFRM_B};

  logic [FEBE_NUM_EPOS-1:0] pos_hit;
  logic                     in_sync;

  // one comparator per E-bit frame position
  for (genvar g = 0; g < FEBE_NUM_EPOS; g++) begin : g_pos
    assign pos_hit[g] = (frm_idx == FRM_W'(EPOS[g]));
  end

  // signalling loss only gates counting when the variant asks for it
  assign in_sync = !los_fas && !los_crc && !(CAS_GATES && los_cas);

  assign err_evt = bit_en && frm_start && (|pos_hit) && !rx_bit && in_sync;
endmodule

// File: rtl/febe_run_cnt.sv
module febe_run_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_evt,
  input  logic             snap,
  input  logic             clr,
  output logic [CNT_W-1:0] run_cnt,
  output logic [CNT_W-1:0] snap_val
);
  import febe_pkg::*;

  febe_act_e        act;
  logic [CNT_W-1:0] run_nx;
  logic             run_en;

  // the event of the snapshot cycle goes into the snapshot, not the next second
  assign snap_val = run_cnt + {{(CNT_W-1){1'b0}}, err_evt};

  always_comb begin
    if (clr)          act = ACT_CLR;
    else if (snap)    act = ACT_SNAP;
    else if (err_evt) act = ACT_INC;
    else              act = ACT_HOLD;
  end

  always_comb begin
    run_en = 1'b1;
    run_nx = run_cnt;
    case (act)
      ACT_CLR, ACT_SNAP: run_nx = '0;
      ACT_INC:           run_nx = snap_val;
      default:           run_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (run_en) run_cnt <= run_nx;
  end
endmodule

// File: rtl/febe_hold_reg.sv
module febe_hold_reg #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clr,
  input  logic [CNT_W-1:0]  din,
  output logic [BYTE_W-1:0] hi,
  output logic [BYTE_W-1:0] lo
);
  logic [CNT_W-1:0] hold_q;
  logic [CNT_W-1:0] hold_nx;
  logic             hold_en;

  always_comb begin
    hold_en = clr || load;
    hold_nx = clr ? '0 : din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_nx;
  end

  assign hi = hold_q[CNT_W-1:BYTE_W];
  assign lo = hold_q[BYTE_W-1:0];
endmodule

// File: rtl/febe_counter.sv
module febe_counter #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned FRM_W     = 4,
  parameter int unsigned EFRM_A    = 13,
  parameter int unsigned EFRM_B    = 15,
  parameter bit          CAS_GATES = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              frm_start,
  input  logic [FRM_W-1:0]  frm_idx,
  input  logic              los_fas,
  input  logic              los_crc,
  input  logic              los_cas,
  input  logic              snap,
  input  logic              clr,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic [BYTE_W-1:0] cnt_lo
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             err_evt;
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] snap_val;

  // asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  febe_ebit_qual #(
    .FRM_W(FRM_W), .EFRM_A(EFRM_A), .EFRM_B(EFRM_B), .CAS_GATES(CAS_GATES)
  ) u_qual (
    .bit_en(bit_en), .frm_start(frm_start), .frm_idx(frm_idx), .rx_bit(rx_bit),
    .los_fas(los_fas), .los_crc(los_crc), .los_cas(los_cas), .err_evt(err_evt)
  );

  febe_run_cnt #(.CNT_W(CNT_W)) u_run (
    .clk(clk), .rst_n(rst_sync_n), .err_evt(err_evt), .snap(snap), .clr(clr),
    .run_cnt(run_cnt), .snap_val(snap_val)
  );

  febe_hold_reg #(.BYTE_W(BYTE_W)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .load(snap), .clr(clr), .din(snap_val),
    .hi(cnt_hi), .lo(cnt_lo)
  );
endmodule

// File: rtl/febe_counter_chk.sv
module febe_counter_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned FRM_W  = 4,
  parameter int unsigned EFRM_A = 13,
  parameter int unsigned EFRM_B = 15,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              rx_bit,
  input logic              frm_start,
  input logic [FRM_W-1:0]  frm_idx,
  input logic              los_fas,
  input logic              los_crc,
  input logic              los_cas,
  input logic              snap,
  input logic              clr,
  input logic [CNT_W-1:0]  run_cnt,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic [BYTE_W-1:0] cnt_lo
);
  logic at_epos;
  logic zero_ebit;
  logic [CNT_W-1:0] rd_val;

  assign at_epos   = bit_en && frm_start &&
                     (frm_idx == FRM_W'(EFRM_A) || frm_idx == FRM_W'(EFRM_B));
  assign zero_ebit = at_epos && !rx_bit;
  assign rd_val    = {cnt_hi, cnt_lo};

  p_reset_zero_r1: assert property (@(posedge clk) $rose(rst_n) |-> rd_val == '0 && run_cnt == '0);

  p_off_position_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_epos && !snap && !clr) |=> $stable(run_cnt));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_ebit && !los_fas && !los_crc && !snap && !clr) |=> run_cnt == $past(run_cnt) + 1'b1);

  p_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_epos && rx_bit && !snap && !clr) |=> $stable(run_cnt));

  p_sync_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((los_fas || los_crc) && !snap && !clr) |=> $stable(run_cnt));

  p_cas_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (los_cas && zero_ebit && !los_fas && !los_crc && !snap && !clr) |=> run_cnt != $past(run_cnt));

  p_snap_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snap && !clr) |=> run_cnt == '0 &&
      rd_val == $past(run_cnt) + CNT_W'($past(zero_ebit && !los_fas && !los_crc)));

  p_read_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap && !clr) |=> $stable(rd_val));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> run_cnt == '0 && rd_val == '0);
endmodule

bind febe_counter febe_counter_chk #(
  .BYTE_W(BYTE_W), .FRM_W(FRM_W), .EFRM_A(EFRM_A), .EFRM_B(EFRM_B)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bit_en(bit_en), .rx_bit(rx_bit),
  .frm_start(frm_start), .frm_idx(frm_idx), .los_fas(los_fas),
  .los_crc(los_crc), .los_cas(los_cas), .snap(snap), .clr(clr),
  .run_cnt(run_cnt), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo)
);

// File: tb/tb_febe_counter.sv
module tb_febe_counter;
  logic       clk;
  logic       rst_n;
  logic       bit_en, rx_bit, frm_start;
  logic [3:0] frm_idx;
  logic       los_fas, los_crc, los_cas, snap, clr;
  logic [7:0] cnt_hi, cnt_lo;

  int unsigned n_chk;
  int unsigned n_fail;
  bit          done;
  logic [15:0] run_m;
  logic [15:0] hold_m;

  febe_counter dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .frm_start(frm_start), .frm_idx(frm_idx), .los_fas(los_fas),
    .los_crc(los_crc), .los_cas(los_cas), .snap(snap), .clr(clr),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected error event, taken from R2 to R5
  function automatic bit exp_err(bit en, bit fs, logic [3:0] idx, bit rb, bit lf, bit lc);
    return en && fs && (idx == 4'd13 || idx == 4'd15) && !rb && !lf && !lc;
  endfunction

  task automatic step(bit en, bit fs, logic [3:0] idx, bit rb,
                      bit lf, bit lc, bit lk, bit sn, bit cl);
    bit e;
    bit_en = en; frm_start = fs; frm_idx = idx; rx_bit = rb;
    los_fas = lf; los_crc = lc; los_cas = lk; snap = sn; clr = cl;
    @(posedge clk);
    e = exp_err(en, fs, idx, rb, lf, lc);
    if (cl) begin
      run_m = '0; hold_m = '0;
    end else if (sn) begin
      hold_m = run_m + 16'(e); run_m = '0;
    end else begin
      run_m = run_m + 16'(e);
    end
    @(negedge clk);
  endtask

  task automatic idle(); step(0, 0, 4'd0, 1, 0, 0, 0, 0, 0); endtask
  task automatic ebit(bit rb, bit lf, bit lc, bit lk);
    step(1, 1, 4'd13, rb, lf, lc, lk, 0, 0);
  endtask
  task automatic take(); step(0, 0, 4'd0, 1, 0, 0, 0, 1, 0); endtask

  task automatic check(string req, logic [15:0] exp);
    n_chk++;
    if ({cnt_hi, cnt_lo} !== exp || hold_m !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, {cnt_hi, cnt_lo}, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_900_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0; run_m = '0; hold_m = '0;
    bit_en = 0; rx_bit = 1; frm_start = 0; frm_idx = '0;
    los_fas = 0; los_crc = 0; los_cas = 0; snap = 0; clr = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle();
    check("R1", 16'd0);

    // R3: single zero E-bit in frame 13
    ebit(0, 0, 0, 0); take(); check("R3", 16'd1);
    // R2/R3: frame 15 counts, a one in frame 13 does not
    step(1, 1, 4'd15, 0, 0, 0, 0, 0, 0); ebit(1, 0, 0, 0); take(); check("R2", 16'd1);
    // R2: off-position zeros
    step(1, 1, 4'd14, 0, 0, 0, 0, 0, 0);
    step(1, 0, 4'd13, 0, 0, 0, 0, 0, 0);
    step(0, 1, 4'd15, 0, 0, 0, 0, 0, 0);
    step(1, 1, 4'd0,  0, 0, 0, 0, 0, 0);
    take(); check("R2", 16'd0);
    // R4: sync loss gates
    ebit(0, 1, 0, 0); ebit(0, 0, 1, 0); ebit(0, 1, 1, 1); take(); check("R4", 16'd0);
    // R5: signalling loss alone still counts
    ebit(0, 0, 0, 1); ebit(0, 0, 0, 1); take(); check("R5", 16'd2);
    // R6: error coinciding with the snapshot lands in it, and not in the next
    ebit(0, 0, 0, 0); ebit(0, 0, 0, 0); ebit(0, 0, 0, 0);
    step(1, 1, 4'd15, 0, 0, 0, 0, 1, 0); check("R6", 16'd4);
    take(); check("R6", 16'd0);
    // R7: readout holds while the running count moves
    ebit(0, 0, 0, 0); ebit(0, 0, 0, 0); check("R7", 16'd0);
    take(); check("R7", 16'd2);
    // R8: clear beats snapshot and error
    ebit(0, 0, 0, 0);
    step(1, 1, 4'd13, 0, 0, 0, 0, 1, 1); check("R8", 16'd0);
    take(); check("R8", 16'd0);
    // R9: wrap after 65536 errors
    for (int i = 0; i < 65537; i++) ebit(0, 0, 0, 0);
    take(); check("R9", 16'd1);

    // constrained random, seeded, checked every cycle against the model
    void'($urandom(32'h0000_FEB5));
    for (int i = 0; i < 5000; i++) begin
      logic [3:0] idx;
      idx = ($urandom % 2 != 0) ? (($urandom % 2 != 0) ? 4'd13 : 4'd15) : 4'($urandom % 16);
      step($urandom % 4 != 0, $urandom % 2 != 0, idx, $urandom % 2 != 0,
           $urandom % 8 == 0, $urandom % 8 == 0, $urandom % 4 == 0,
           $urandom % 40 == 0, $urandom % 400 == 0);
      check("R7", hold_m);
    end
    take(); check("R6", hold_m);
    finish_run();
  end
endmodule